// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave Model

This block models a small serial EEPROM as it looks to a host. The host drives a select line, a serial clock and a data-in line. The block returns one data-out bit with its own output enable, so that a tri-state pad can be placed outside the block. A command frame opens with a start bit. Next come a two-bit opcode, an address field and, for write-type commands, a data field. The block decodes seven operations: word read with sequential streaming, word write, word erase, erase-all, write-all, programming enable and programming disable. A register array holds the contents. The self-timed programming cycle is a down-counter that runs on the system clock, with its lengths set by parameters.

Two static straps set the behaviour. `org_x16` selects 16-bit words or 8-bit bytes. `prog_en` gates every change to the array, together with an internal enable latch. While a programming cycle runs, and after it for as long as select stays high, the data-out line reports ready/busy status. A host can poll that status without opening a new frame. The serial clock is sampled by the system clock, so it must be several system clocks slower than `clk`.

Top module: `sprom_slave`

## Requirements
- R1: A frame starts at the first rising `sck` edge at which `cs` and `di` are both high. Rising edges before that, with `di` low or with `cs` low, change nothing, and `dout_oe` stays 0.
- R2: The two bits after the start bit select the operation: 10 is read, 01 is write and 11 is erase. With 00, the first two bits of the address field choose the operation: 11 is enable, 00 is disable, 10 is erase-all and 01 is write-all. The remaining address bits are ignored. Enable and disable leave `dout_oe` at 0.
- R3: With `org_x16`=1 the address field has ADDR_W bits and the data field has 16 bits. With `org_x16`=0 they have ADDR_W+1 and 8 bits. A byte address b selects word b>>1, with bits [7:0] when b[0]=0 and bits [15:8] when b[0]=1.
- R4: After a read command, `dout` is 0 (a dummy bit) following the `sck` rise that takes the last address bit. Each later rise then presents the next data bit, MSB first.
- R5: While `cs` stays high, a read continues with the next address after the last bit of a word. The address wraps from the top address to 0.
- R6: The enable latch is cleared by reset and by disable, and set by enable. A write, erase, erase-all or write-all changes the array only when the latch is set and `prog_en` is 1. A blocked command leaves the array unchanged and shows ready at once. Reads ignore the latch.
- R7: Erase sets the addressed word or byte to all ones. Erase-all sets every word to all ones. Write-all stores its data in every word, or in every byte in 8-bit mode.
- R8: Programming starts at the `sck` rise that takes the last required bit: the last address bit for erase and erase-all, the last data bit for write and write-all. Busy then lasts PROG_CYC system clocks for single-location operations, ERAL_CYC for erase-all and WRAL_CYC for write-all.
- R9: After a programming command, while `cs` is high, `dout_oe` is 1 and `dout` shows 0 while busy and 1 when ready. This holds until a new start bit. Start bits seen while busy are ignored, and a start bit after ready opens a new frame.
- R10: Taking `cs` low forces `dout_oe` to 0 and returns the command logic to waiting for a start bit. A programming cycle already running still completes.
- R11: After reset every array bit is 1, the latch is clear and `dout_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial inputs |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Select; low resets the command logic |
| sck | input | 1 | Serial clock from the host |
| di | input | 1 | Serial data from the host |
| org_x16 | input | 1 | Strap: 1 selects 16-bit words, 0 selects 8-bit bytes |
| prog_en | input | 1 | Strap: 1 allows array programming |
| dout | output | 1 | Serial read data or ready/busy status |
| dout_oe | output | 1 | Output enable for `dout` |

## Verification
The bound checker watches these on every cycle: the output is released whenever select is low, and an array update always has the enable latch and the strap behind it. It also checks that the array never changes without a programming pulse, that no programming cycle restarts while one is running, that busy always reads as 0, and that the output is driven throughout a read. Only the bench scenarios can show the data contents against a reference model in both organizations. The same holds for the dummy bit and streaming order, the exact busy lengths of each operation kind, a busy cycle that completes after deselect, and the acceptance of a new frame once status reads ready.

// File: rtl/sprom_pkg.sv
package sprom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_READ,
        ST_STATUS,
        ST_HOLD
    } sprom_state_e;

    typedef enum logic [1:0] {
        PG_WORD,
        PG_ERASE,
        PG_ERALL,
        PG_WRALL
    } pg_kind_e;

endpackage

// File: rtl/sprom_edge.sv
module sprom_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    output logic rise
);
    logic sck_d, sck_q;

    always_comb begin
        sck_d = sck;
        rise  = sck & ~sck_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_d;
    end
endmodule

// File: rtl/sprom_timer.sv
module sprom_timer #(
    parameter int TMR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] val,
    output logic             busy
);
    logic [TMR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)             cnt_d = val;
        else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        busy = (cnt_q != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/sprom_array.sv
module sprom_array #(
    parameter int ADDR_W = 4,
    localparam int WORDS = 1 << ADDR_W,
    localparam int MEM_BITS = WORDS * 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  sprom_pkg::pg_kind_e  kind,
    input  logic                 x16,
    input  logic [ADDR_W:0]      waddr,
    input  logic [15:0]          wdata,
    input  logic [ADDR_W:0]      raddr,
    output logic [15:0]          rdata,
    output logic [MEM_BITS-1:0]  mem_flat
);
    import sprom_pkg::*;

    for (genvar g = 0; g < WORDS; g++) begin : g_word
        logic [15:0] word_d, word_q;
        logic        hit;

        always_comb begin
            hit    = x16 ? (waddr[ADDR_W-1:0] == ADDR_W'(g))
                         : (waddr[ADDR_W:1]   == ADDR_W'(g));
            word_d = word_q;
            if (we) begin
                unique case (kind)
                    PG_WORD:  if (hit) begin
                        if (x16)           word_d = wdata;
                        else if (waddr[0]) word_d = {wdata[7:0], word_q[7:0]};
                        else               word_d = {word_q[15:8], wdata[7:0]};
                    end
                    PG_ERASE: if (hit) begin
                        if (x16)           word_d = 16'hFFFF;
                        else if (waddr[0]) word_d = {8'hFF, word_q[7:0]};
                        else               word_d = {word_q[15:8], 8'hFF};
                    end
                    PG_ERALL: word_d = 16'hFFFF;
                    PG_WRALL: word_d = x16 ? wdata : {wdata[7:0], wdata[7:0]};
                    default:  word_d = word_q;
                endcase
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) word_q <= 16'hFFFF;
            else        word_q <= word_d;
        end

        assign mem_flat[g*16 +: 16] = word_q;
    end

    logic [15:0] sel_w;
    always_comb begin
        if (x16) begin
            sel_w = mem_flat[raddr[ADDR_W-1:0]*16 +: 16];
            rdata = sel_w;
        end else begin
            sel_w = mem_flat[raddr[ADDR_W:1]*16 +: 16];
            rdata = {8'h00, raddr[0] ? sel_w[15:8] : sel_w[7:0]};
        end
    end
endmodule

// File: rtl/sprom_slave.sv
module sprom_slave #(
    parameter int ADDR_W   = 4,
    parameter int PROG_CYC = 40,
    parameter int ERAL_CYC = 60,
    parameter int WRAL_CYC = 120
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic sck,
    input  logic di,
    input  logic org_x16,
    input  logic prog_en,
    output logic dout,
    output logic dout_oe
);
    import sprom_pkg::*;

    localparam int AW8      = ADDR_W + 1;
    localparam int CMD_W    = AW8 + 2;
    localparam int MAXB     = (CMD_W > 16) ? CMD_W : 16;
    localparam int BC_W     = $clog2(MAXB + 1);
    localparam int TMR_W    = $clog2(WRAL_CYC + 1);
    localparam int MEM_BITS = 16 * (1 << ADDR_W);

    typedef struct packed {
        sprom_state_e      st;
        logic [BC_W-1:0]   bc;
        logic [CMD_W-1:0]  sr;
        logic [AW8-1:0]    addr;
        logic [15:0]       wd;
        logic [15:0]       osh;
        logic              dout;
        logic              wen;
        pg_kind_e          pk;
    } regs_t;

    regs_t r_d, r_q;

    logic                rise, busy, wr_go, tmr_load, in_read;
    logic [TMR_W-1:0]    tmr_val;
    pg_kind_e            pg_kind;
    logic [AW8-1:0]      pg_addr, adr_c, addr_inc, rd_a;
    logic [15:0]         pg_data, rd_w, just_w;
    logic [CMD_W-1:0]    sr_nx;
    logic [1:0]          opc_c, qual_c;
    logic [BC_W-1:0]     last_cmd, dw;
    logic [MEM_BITS-1:0] mem_flat;

    sprom_edge u_edge (.clk(clk), .rst_n(rst_n), .sck(sck), .rise(rise));

    sprom_timer #(.TMR_W(TMR_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .busy(busy)
    );

    sprom_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .rst_n(rst_n), .we(wr_go), .kind(pg_kind), .x16(org_x16),
        .waddr(pg_addr), .wdata(pg_data), .raddr(rd_a), .rdata(rd_w),
        .mem_flat(mem_flat)
    );

    // Frame field extraction and read address selection
    always_comb begin
        sr_nx    = {r_q.sr[CMD_W-2:0], di};
        adr_c    = org_x16 ? {1'b0, sr_nx[ADDR_W-1:0]} : sr_nx[AW8-1:0];
        opc_c    = org_x16 ? sr_nx[ADDR_W+1:ADDR_W] : sr_nx[AW8+1:AW8];
        qual_c   = org_x16 ? sr_nx[ADDR_W-1:ADDR_W-2] : sr_nx[AW8-1:AW8-2];
        last_cmd = org_x16 ? BC_W'(ADDR_W + 1) : BC_W'(AW8 + 1);
        dw       = org_x16 ? BC_W'(16) : BC_W'(8);
        addr_inc = org_x16 ? {1'b0, r_q.addr[ADDR_W-1:0] + 1'b1} : r_q.addr + 1'b1;
        rd_a     = (r_q.st == ST_CMD) ? adr_c : addr_inc;
        just_w   = org_x16 ? rd_w : {rd_w[7:0], 8'h00};
    end

    // Next-state logic
    always_comb begin
        logic     go;
        pg_kind_e gk;
        logic [15:0] wd_nx;
        r_d      = r_q;
        go       = 1'b0;
        gk       = PG_WORD;
        wd_nx    = {r_q.wd[14:0], di};
        wr_go    = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        pg_kind  = r_q.pk;
        pg_addr  = r_q.addr;
        pg_data  = r_q.wd;

        if (!cs) begin
            r_d.st = ST_IDLE;
        end else if (rise) begin
            unique case (r_q.st)
                ST_IDLE, ST_STATUS: if (di && !busy) begin
                    r_d.st = ST_CMD;
                    r_d.bc = '0;
                    r_d.sr = '0;
                end
                ST_CMD: begin
                    r_d.sr = sr_nx;
                    r_d.bc = r_q.bc + 1'b1;
                    if (r_q.bc == last_cmd) begin
                        r_d.addr = adr_c;
                        r_d.bc   = '0;
                        r_d.wd   = '0;
                        unique case (opc_c)
                            2'b10: begin
                                r_d.st   = ST_READ;
                                r_d.osh  = just_w;
                                r_d.bc   = dw;
                                r_d.dout = 1'b0;
                            end
                            2'b01: begin r_d.st = ST_DATA; r_d.pk = PG_WORD; end
                            2'b11: begin go = 1'b1; gk = PG_ERASE; pg_addr = adr_c; end
                            default: unique case (qual_c)
                                2'b11:   begin r_d.wen = 1'b1; r_d.st = ST_HOLD; end
                                2'b00:   begin r_d.wen = 1'b0; r_d.st = ST_HOLD; end
                                2'b10:   begin go = 1'b1; gk = PG_ERALL; end
                                default: begin r_d.st = ST_DATA; r_d.pk = PG_WRALL; end
                            endcase
                        endcase
                    end
                end
                ST_DATA: begin
                    r_d.wd = wd_nx;
                    r_d.bc = r_q.bc + 1'b1;
                    if (r_q.bc == dw - 1'b1) begin
                        go      = 1'b1;
                        gk      = r_q.pk;
                        pg_data = wd_nx;
                    end
                end
                ST_READ: begin
                    if (r_q.bc == '0) begin
                        r_d.dout = just_w[15];
                        r_d.osh  = {just_w[14:0], 1'b0};
                        r_d.bc   = dw - 1'b1;
                        r_d.addr = addr_inc;
                    end else begin
                        r_d.dout = r_q.osh[15];
                        r_d.osh  = {r_q.osh[14:0], 1'b0};
                        r_d.bc   = r_q.bc - 1'b1;
                    end
                end
                default: r_d = r_q;
            endcase
        end

        if (go) begin
            r_d.st  = ST_STATUS;
            pg_kind = gk;
            if (r_q.wen && prog_en) begin
                wr_go    = 1'b1;
                tmr_load = 1'b1;
                unique case (gk)
                    PG_ERALL: tmr_val = TMR_W'(ERAL_CYC);
                    PG_WRALL: tmr_val = TMR_W'(WRAL_CYC);
                    default:  tmr_val = TMR_W'(PROG_CYC);
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.pk   <= PG_WORD;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        in_read = (r_q.st == ST_READ);
        dout_oe = cs && (in_read || r_q.st == ST_STATUS || (r_q.st == ST_IDLE && busy));
        dout    = in_read ? r_q.dout : ~busy;
    end
endmodule

// File: rtl/sprom_slave_chk.sv
module sprom_slave_chk #(
    parameter int MEM_W = 256
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs,
    input logic             prog_en,
    input logic             dout,
    input logic             dout_oe,
    input logic             busy,
    input logic             wr_go,
    input logic             tmr_load,
    input logic             wen,
    input logic             in_read,
    input logic [MEM_W-1:0] mem_flat
);
    AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !dout_oe); // R10

    AST_PROTECTED_PROGRAM: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |-> (wen && prog_en)); // R6

    AST_ARRAY_CHANGES_ONLY_ON_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mem_flat) |-> $past(wr_go)); // R7

    AST_NO_RESTART_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_load |-> !busy); // R9

    AST_LOAD_MAKES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_load |=> busy); // R8

    AST_BUSY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dout_oe && busy && !in_read) |-> !dout); // R9

    AST_READ_DRIVES_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_read && cs) |-> dout_oe); // R4
endmodule

bind sprom_slave sprom_slave_chk #(.MEM_W(MEM_BITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs(cs), .prog_en(prog_en), .dout(dout),
    .dout_oe(dout_oe), .busy(busy), .wr_go(wr_go), .tmr_load(tmr_load),
    .wen(r_q.wen), .in_read(in_read), .mem_flat(mem_flat)
);

// File: tb/tb_sprom_slave.sv
module tb_sprom_slave;
    localparam int AW = 4, PC = 40, EC = 60, WC = 120;

    logic clk = 0, rst_n = 0, cs = 0, sck = 0, di = 0, org = 1, pe = 1;
    wire  dout, dout_oe;
    always #5 clk = ~clk;

    sprom_slave #(.ADDR_W(AW), .PROG_CYC(PC), .ERAL_CYC(EC), .WRAL_CYC(WC)) dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .di(di),
        .org_x16(org), .prog_en(pe), .dout(dout), .dout_oe(dout_oe)
    );

    int n_chk = 0, n_fail = 0;
    logic [15:0] refm [16];
    logic tb_wen = 0;
    logic so;

    task automatic chk_eq(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic sbit(input logic b);
        @(negedge clk); di = b; sck = 1;
        @(negedge clk); so = dout;
        @(negedge clk); sck = 0;
        @(negedge clk);
    endtask

    task automatic sendv(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) sbit(v[i]);
    endtask

    function automatic int aw_now(); return org ? AW : AW + 1; endfunction
    function automatic int dw_now(); return org ? 16 : 8; endfunction
    function automatic logic [4:0] qual(input logic [1:0] q);
        return 5'(q) << (aw_now() - 2);
    endfunction

    function automatic logic [15:0] ref_rd(input logic [4:0] a);
        if (org) return refm[a[3:0]];
        return a[0] ? {8'h00, refm[a[4:1]][15:8]} : {8'h00, refm[a[4:1]][7:0]};
    endfunction

    task automatic cmd(input logic [1:0] op, input logic [4:0] a);
        @(negedge clk); cs = 1;
        sbit(1);
        sendv({14'b0, op}, 2);
        sendv({11'b0, a}, aw_now());
    endtask

    task automatic deselect();
        @(negedge clk); cs = 0; di = 0;
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        while (dout !== 1'b1 && n < 1000) begin n++; @(negedge clk); end
    endtask

    task automatic rd_check(input logic [4:0] a, input int nw, input string req);
        logic [4:0]  cur;
        logic [15:0] v;
        cmd(2'b10, a);
        chk_eq({req, " dummy bit"}, so, 0);
        cur = a;
        for (int w = 0; w < nw; w++) begin
            v = 0;
            for (int i = 0; i < dw_now(); i++) begin sbit(0); v = {v[14:0], so}; end
            chk_eq(req, v, ref_rd(cur));
            cur = org ? 5'((cur + 1) & 15) : 5'((cur + 1) & 31);
        end
        deselect();
    endtask

    task automatic ref_apply(input int kind, input logic [4:0] a, input logic [15:0] d);
        case (kind)
            0: if (org) refm[a[3:0]] = d;
               else if (a[0]) refm[a[4:1]][15:8] = d[7:0];
               else refm[a[4:1]][7:0] = d[7:0];
            1: if (org) refm[a[3:0]] = 16'hFFFF;
               else if (a[0]) refm[a[4:1]][15:8] = 8'hFF;
               else refm[a[4:1]][7:0] = 8'hFF;
            2: for (int i = 0; i < 16; i++) refm[i] = 16'hFFFF;
            default: for (int i = 0; i < 16; i++) refm[i] = org ? d : {d[7:0], d[7:0]};
        endcase
    endtask

    // kind: 0 write, 1 erase, 2 erase-all, 3 write-all
    task automatic prog(input int kind, input logic [4:0] a, input logic [15:0] d,
                        input string req, input bit timing);
        bit eff;
        int n, cyc;
        eff = tb_wen && pe;
        case (kind)
            0: begin cmd(2'b01, a); sendv(d, dw_now()); end
            1: cmd(2'b11, a);
            2: cmd(2'b00, qual(2'b10));
            default: begin cmd(2'b00, qual(2'b01)); sendv(d, dw_now()); end
        endcase
        cyc = (kind == 2) ? EC : (kind == 3) ? WC : PC;
        chk_eq({req, " R9 status driven"}, dout_oe, 1);
        chk_eq({req, " R9 busy/ready level"}, dout, eff ? 0 : 1);
        if (eff) begin
            wait_ready(n);
            if (timing) begin
                n_chk++;
                if (n < cyc - 3 || n > cyc - 1) begin
                    n_fail++;
                    $display("FAIL R8 busy length actual=%0d expected=%0d", n, cyc - 2);
                end
            end
            ref_apply(kind, a, d);
            chk_eq({req, " R9 ready after cycle"}, dout, 1);
        end
        deselect();
    endtask

    task automatic ctl(input logic [1:0] q);
        cmd(2'b00, qual(q));
        chk_eq("R2 enable/disable leaves output off", dout_oe, 0);
        deselect();
        tb_wen = (q == 2'b11);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        logic [4:0]  ra;
        logic [15:0] rd;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 16; i++) refm[i] = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk_eq("R11 output off after reset", dout_oe, 0);
        rd_check(5'd3, 1, "R11 erased contents after reset");

        // R1: clocks before a start bit
        for (int i = 0; i < 3; i++) begin sbit(1); chk_eq("R1 cs low clocks ignored", dout_oe, 0); end
        @(negedge clk); cs = 1;
        for (int i = 0; i < 5; i++) begin sbit(0); chk_eq("R1 di low clocks ignored", dout_oe, 0); end
        rd_check(5'd2, 1, "R1 frame after idle clocks");

        // R6: programming blocked right after reset
        prog(0, 5'd1, 16'h1111, "R6 write before enable", 0);
        rd_check(5'd1, 1, "R6 blocked write unchanged");

        ctl(2'b11);
        prog(0, 5'd5, 16'hA5C3, "R8 word write", 1);
        rd_check(5'd5, 1, "R4 read after write");

        // R9: start bits ignored while busy, new frame after ready
        cmd(2'b01, 5'd6); sendv(16'h0F0F, 16);
        chk_eq("R9 busy right after last bit", dout, 0);
        sbit(1); chk_eq("R9 start ignored while busy", so, 0);
        sbit(1); sbit(0);
        chk_eq("R9 still status while busy", dout_oe, 1);
        chk_eq("R9 still busy", dout, 0);
        wait_ready(n);
        chk_eq("R9 ready held", dout, 1);
        ref_apply(0, 5'd6, 16'h0F0F);
        rd_check(5'd6, 1, "R9 new frame after ready");

        // R10: deselect during programming
        cmd(2'b01, 5'd7); sendv(16'hBEEF, 16);
        deselect();
        chk_eq("R10 output off when deselected", dout_oe, 0);
        repeat (PC) @(negedge clk);
        ref_apply(0, 5'd7, 16'hBEEF);
        rd_check(5'd7, 1, "R10 cycle completes after deselect");

        // R3: byte organisation
        org = 0;
        prog(0, 5'd9, 16'h003C, "R3 byte write high", 1);
        prog(0, 5'd8, 16'h00D2, "R3 byte write low", 0);
        rd_check(5'd9, 1, "R3 byte read high half");
        rd_check(5'd8, 1, "R3 byte read low half");
        org = 1;
        rd_check(5'd4, 1, "R3 word holds both bytes");

        // R5: sequential reads with wrap
        rd_check(5'd14, 4, "R5 word stream wraps");
        org = 0;
        rd_check(5'd31, 3, "R5 byte stream wraps");

        // R7: erase in both organisations
        prog(1, 5'd9, 16'h0, "R7 byte erase", 1);
        rd_check(5'd8, 2, "R7 byte erase result");
        org = 1;
        prog(1, 5'd5, 16'h0, "R7 word erase", 1);
        rd_check(5'd5, 1, "R7 word erase result");

        // R6: strap low blocks
        pe = 0;
        prog(0, 5'd2, 16'h2222, "R6 strap low write", 0);
        prog(2, 5'd0, 16'h0, "R6 strap low erase-all", 0);
        rd_check(5'd6, 2, "R6 strap low unchanged");
        pe = 1;

        prog(3, 5'd0, 16'h1234, "R8 write-all x16", 1);
        rd_check(5'd0, 3, "R7 write-all x16 result");
        org = 0;
        prog(3, 5'd0, 16'h005A, "R8 write-all x8", 1);
        rd_check(5'd17, 2, "R7 write-all x8 result");
        org = 1;
        prog(2, 5'd0, 16'h0, "R8 erase-all", 1);
        rd_check(5'd10, 2, "R7 erase-all result");

        // R6: disable blocks
        ctl(2'b00);
        prog(0, 5'd3, 16'h3333, "R6 write after disable", 0);
        rd_check(5'd3, 1, "R6 disabled write unchanged");

        // Random mix
        ctl(2'b11);
        for (int it = 0; it < 50; it++) begin
            org = 1'($urandom % 2);
            ra  = 5'($urandom % (org ? 16 : 32));
            rd  = 16'($urandom);
            case ($urandom % 4)
                0: prog(0, ra, rd, "R2 random write", 0);
                1: prog(1, ra, rd, "R7 random erase", 0);
                default: rd_check(ra, 1 + int'($urandom % 2), "R4 random read");
            endcase
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule